// File: doc/BRIEF.md
# Fetch-Stream Instruction Pattern Matcher

This block watches every instruction word handed over by the instruction cache, ahead of the native decoder, and checks it against a small programmable table of pattern entries. Each entry holds a compare value, a care mask that selects which bits must equal that value, a flag that constrains only the sign of the 16-bit immediate, an 8-bit replacement-sequence identifier and a valid bit. With the mask, a pattern can pin down a full opcode, only the opcode class, a particular register in one of the register fields, or any mix of these. Bits outside the mask are ignored.

When several entries hit the same word, the winner is the entry that constrains the most bits. Its weight is the number of ones in its care mask, plus one if its sign-only flag is set. Equal weights go to the lower entry index. One cycle after an instruction is accepted, the block presents the accepted word together with a hit flag and the winning sequence identifier. On a miss, the identifier reads zero and the word passes through untouched. Software loads the table through a single write port. An instruction is never accepted in a cycle where that port is active, so no word is ever matched against an entry that is part-way through an update.

The instruction layout assumed is: opcode in bits 31:26, opcode class in bits 31:29, first source register in 25:21, second register in 20:16, destination register in 15:11 and a 16-bit immediate in 15:0, with its sign in bit 15.

Top module: `instPatternTable`

## Requirements
- R1: After reset, outValid, outHit and outSeqId are 0 and every entry is invalid, so the first instruction accepted misses.
- R2: instReady is 0 in exactly those cycles where wrEn is 1. An instruction is accepted when instValid and instReady are both 1.
- R3: outValid is 1 in the cycle after an acceptance and 0 otherwise. While outValid is 0, outHit and outSeqId are 0.
- R4: A valid entry hits when every bit set in its care mask matches the same bit of its value. Bits with a 0 in the mask have no effect on the match.
- R5: An entry whose mask covers only bits 31:29 hits every opcode in that class.
- R6: An entry whose mask includes a register field (for example bits 25:21 = 29) hits only words that name that register in that field.
- R7: With the sign-only flag set, an entry additionally requires bit 15 of the word to equal bit 15 of its value. The flag adds one to the entry's weight.
- R8: When several entries hit, the one with the largest weight (mask popcount plus sign-only flag) supplies outSeqId.
- R9: Among hitting entries of equal weight, the lowest index wins.
- R10: On a miss, outHit is 0 and outSeqId is 0.
- R11: An entry written with wrValid = 0 never hits until it is written again with wrValid = 1.
- R12: When outValid is 1, outWord equals the instruction word accepted in the previous cycle, whether it hit or missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrIdx | input | 5 | Entry index to write |
| wrValid | input | 1 | Valid bit stored in the entry |
| wrValue | input | 32 | Compare value |
| wrMask | input | 32 | Care mask (1 = bit must match) |
| wrSignOnly | input | 1 | Immediate sign constraint enable |
| wrSeqId | input | 8 | Replacement-sequence identifier |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Block can take the word this cycle |
| instWord | input | 32 | Fetched instruction word |
| outValid | output | 1 | Result valid |
| outHit | output | 1 | A pattern matched |
| outSeqId | output | 8 | Winning sequence identifier, 0 on miss |
| outWord | output | 32 | Accepted instruction word |

## Verification
Directed words are chosen so that each one separates two possible outcomes. A store through register 29 tells the register-qualified entry apart from the plain opcode entry and the class entry. A store through another register tells the lower-index winner apart from an equal-weight rival. A negative branch tells the sign-qualified entry apart from its unsigned twin, and an opcode inside the store class but not equal to it tells class matching apart from exact-opcode matching. After that, a long random stream mixes words near the loaded patterns with table rewrites issued while instructions are still offered. A behavioural model checks hit, identifier, word and valid on every clock, which exposes stalls, priority errors and stale entries.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef struct packed {
    logic tblWrite;
    logic accept;
  } iptStrobes_t;
endpackage

// File: rtl/iptControl.sv
module iptControl
  import ipt_pkg::*;
(
  input  logic        wrEn,
  input  logic        instValid,
  output logic        instReady,
  output iptStrobes_t strobes
);
  // A table update blocks acceptance so a word never sees a half-written entry.
  always_comb begin
    instReady        = !wrEn;
    strobes.tblWrite = wrEn;
    strobes.accept   = instValid && !wrEn;
  end
endmodule

// File: rtl/iptDatapath.sv
module iptDatapath
  import ipt_pkg::*;
#(
  parameter int NUM_ENTRIES  = 32,
  parameter int INST_W       = 32,
  parameter int SEQ_W        = 8,
  parameter int IMM_SIGN_BIT = 15,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int SPEC_W = $clog2(INST_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  iptStrobes_t       strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [INST_W-1:0] wrValue,
  input  logic [INST_W-1:0] wrMask,
  input  logic              wrSignOnly,
  input  logic [SEQ_W-1:0]  wrSeqId,
  input  logic [INST_W-1:0] instWord,
  output logic              outValid,
  output logic              outHit,
  output logic [SEQ_W-1:0]  outSeqId,
  output logic [INST_W-1:0] outWord
);
  logic [NUM_ENTRIES-1:0] entValid;
  logic [NUM_ENTRIES-1:0] entSign;
  logic [INST_W-1:0]      entValue [NUM_ENTRIES];
  logic [INST_W-1:0]      entMask  [NUM_ENTRIES];
  logic [SEQ_W-1:0]       entSeq   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] hitVec;
  logic [SPEC_W-1:0]      specVec [NUM_ENTRIES];

  // Table storage: only the valid bits need reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
    end else if (strobes.tblWrite) begin
      entValid[wrIdx] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.tblWrite) begin
      entValue[wrIdx] <= wrValue;
      entMask[wrIdx]  <= wrMask;
      entSign[wrIdx]  <= wrSignOnly;
      entSeq[wrIdx]   <= wrSeqId;
    end
  end

  // Per-entry compare and weight.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic maskOk;
    logic signOk;
    assign maskOk = ((instWord ^ entValue[g]) & entMask[g]) == '0;
    assign signOk = !entSign[g] ||
                    (instWord[IMM_SIGN_BIT] == entValue[g][IMM_SIGN_BIT]);
    assign hitVec[g]  = entValid[g] && maskOk && signOk;
    assign specVec[g] = SPEC_W'($countones(entMask[g])) + SPEC_W'(entSign[g]);
  end

  // Winner selection: scanning down with >= leaves the lowest index on ties.
  logic              bestHit;
  logic [SPEC_W-1:0] bestSpec;
  logic [IDX_W-1:0]  bestIdx;

  always_comb begin
    bestHit  = 1'b0;
    bestSpec = '0;
    bestIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i] && (!bestHit || specVec[i] >= bestSpec)) begin
        bestHit  = 1'b1;
        bestSpec = specVec[i];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  // Result register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outSeqId <= '0;
      outWord  <= '0;
    end else if (strobes.accept) begin
      outValid <= 1'b1;
      outHit   <= bestHit;
      outSeqId <= bestHit ? entSeq[bestIdx] : '0;
      outWord  <= instWord;
    end else begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outSeqId <= '0;
    end
  end
endmodule

// File: rtl/instPatternTable.sv
module instPatternTable
  import ipt_pkg::*;
#(
  parameter int NUM_ENTRIES  = 32,
  parameter int INST_W       = 32,
  parameter int SEQ_W        = 8,
  parameter int IMM_SIGN_BIT = 15,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [INST_W-1:0] wrValue,
  input  logic [INST_W-1:0] wrMask,
  input  logic              wrSignOnly,
  input  logic [SEQ_W-1:0]  wrSeqId,
  input  logic              instValid,
  output logic              instReady,
  input  logic [INST_W-1:0] instWord,
  output logic              outValid,
  output logic              outHit,
  output logic [SEQ_W-1:0]  outSeqId,
  output logic [INST_W-1:0] outWord
);
  iptStrobes_t strobes;

  iptControl u_ctrl (
    .wrEn      (wrEn),
    .instValid (instValid),
    .instReady (instReady),
    .strobes   (strobes)
  );

  iptDatapath #(
    .NUM_ENTRIES  (NUM_ENTRIES),
    .INST_W       (INST_W),
    .SEQ_W        (SEQ_W),
    .IMM_SIGN_BIT (IMM_SIGN_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrIdx      (wrIdx),
    .wrValid    (wrValid),
    .wrValue    (wrValue),
    .wrMask     (wrMask),
    .wrSignOnly (wrSignOnly),
    .wrSeqId    (wrSeqId),
    .instWord   (instWord),
    .outValid   (outValid),
    .outHit     (outHit),
    .outSeqId   (outSeqId),
    .outWord    (outWord)
  );
endmodule

// File: rtl/iptChecker.sv
module iptChecker #(
  parameter int INST_W = 32,
  parameter int SEQ_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              instValid,
  input logic              instReady,
  input logic [INST_W-1:0] instWord,
  input logic              outValid,
  input logic              outHit,
  input logic [SEQ_W-1:0]  outSeqId,
  input logic [INST_W-1:0] outWord
);
  AST_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !instReady); // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> instReady); // R2
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> outValid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && instReady) |=> !outValid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outHit && outSeqId == '0)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHit) |-> outSeqId == '0); // R10
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> outWord == $past(instWord)); // R12
endmodule

bind instPatternTable iptChecker #(.INST_W(INST_W), .SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .instValid (instValid),
  .instReady (instReady),
  .instWord  (instWord),
  .outValid  (outValid),
  .outHit    (outHit),
  .outSeqId  (outSeqId),
  .outWord   (outWord)
);

// File: tb/instPatternTable_tb.sv
module instPatternTable_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic        wrValid = 1'b0;
  logic [31:0] wrValue = '0;
  logic [31:0] wrMask = '0;
  logic        wrSignOnly = 1'b0;
  logic [7:0]  wrSeqId = '0;
  logic        instValid = 1'b0;
  logic        instReady;
  logic [31:0] instWord = '0;
  logic        outValid;
  logic        outHit;
  logic [7:0]  outSeqId;
  logic [31:0] outWord;

  always #10 clk = ~clk;  // 50 MHz

  instPatternTable u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid),
    .wrValue(wrValue), .wrMask(wrMask), .wrSignOnly(wrSignOnly),
    .wrSeqId(wrSeqId), .instValid(instValid), .instReady(instReady),
    .instWord(instWord), .outValid(outValid), .outHit(outHit),
    .outSeqId(outSeqId), .outWord(outWord)
  );

  int checks = 0;
  int errors = 0;
  string reqTag = "R1";

  // Behavioural reference model
  bit          mValid [32];
  bit [31:0]   mValue [32];
  bit [31:0]   mMask  [32];
  bit          mSign  [32];
  bit [7:0]    mSeq   [32];
  bit          expValid = 0;
  bit          expHit = 0;
  bit [7:0]    expSeq = 0;
  bit [31:0]   expWord = 0;

  function automatic void modelMatch(input bit [31:0] w, output bit hit, output bit [7:0] seq);
    int best = -1;
    hit = 0;
    seq = 0;
    for (int e = 0; e < 32; e++) begin
      int weight;
      bit ok;
      ok = mValid[e] && (((w ^ mValue[e]) & mMask[e]) == 0);
      if (mSign[e] && (w[15] != mValue[e][15])) ok = 0;
      weight = $countones(mMask[e]) + (mSign[e] ? 1 : 0);
      if (ok && weight > best) begin
        best = weight;
        hit = 1;
        seq = mSeq[e];
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0; expHit = 0; expSeq = 0; expWord = 0;
      for (int e = 0; e < 32; e++) mValid[e] = 0;
    end else begin
      bit h;
      bit [7:0] s;
      if (instValid && !wrEn) begin
        modelMatch(instWord, h, s);
        expValid = 1; expHit = h; expSeq = s; expWord = instWord;
      end else begin
        expValid = 0; expHit = 0; expSeq = 0;
      end
      if (wrEn) begin
        mValid[wrIdx] = wrValid; mValue[wrIdx] = wrValue; mMask[wrIdx] = wrMask;
        mSign[wrIdx] = wrSignOnly; mSeq[wrIdx] = wrSeqId;
      end
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare every clock, after the driver has settled.
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      check("R2", "instReady", instReady, !wrEn);
      check(reqTag, "outValid", outValid, expValid);
      check(reqTag, "outHit", outHit, expHit);
      check(reqTag, "outSeqId", outSeqId, expSeq);
      if (expValid) check(reqTag, "outWord", outWord, expWord);
    end
  end

  task automatic writeEntry(input int idx, input bit v, input bit [31:0] val,
                            input bit [31:0] msk, input bit sgn, input bit [7:0] seq);
    @(negedge clk);
    wrEn = 1; wrIdx = 5'(idx); wrValid = v; wrValue = val; wrMask = msk;
    wrSignOnly = sgn; wrSeqId = seq;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic sendWord(input string tag, input bit [31:0] w, input bit [7:0] want);
    @(negedge clk);
    reqTag = tag;
    instValid = 1; instWord = w;
    @(negedge clk);
    instValid = 0;
    #2;
    check(tag, "directed outSeqId", outSeqId, want);
    check(tag, "directed outHit", outHit, want != 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset outValid", outValid, 0);
    check("R1", "reset outSeqId", outSeqId, 0);
    rstN = 1;
    sendWord("R1", 32'hAC24_0008, 8'd0);                          // empty table misses
    writeEntry(0, 1, 32'hAC00_0000, 32'hFC00_0000, 0, 8'd5);      // exact store opcode
    writeEntry(1, 1, 32'hA000_0000, 32'hE000_0000, 0, 8'd6);      // class 101
    writeEntry(2, 1, 32'hAFA0_0000, 32'hFFE0_0000, 0, 8'd7);      // store via RS=29
    writeEntry(3, 1, 32'h1000_8000, 32'hFC00_0000, 1, 8'd9);      // branch, negative imm
    writeEntry(4, 1, 32'h1000_0000, 32'hFC00_0000, 0, 8'd10);     // branch any
    writeEntry(5, 1, 32'hAC00_0000, 32'hFC00_0000, 0, 8'd11);     // tie rival of entry 0
    sendWord("R6", 32'hAFA4_0008, 8'd7);   // R8: weight 11 beats 6 and 3
    sendWord("R9", 32'hAC24_0008, 8'd5);   // entries 0 and 5 tie, 0 wins
    sendWord("R4", 32'hAC3F_FFFF, 8'd5);   // don't-care fields vary
    sendWord("R5", 32'hA000_0000, 8'd6);   // class-only hit
    sendWord("R7", 32'h1000_FFFC, 8'd9);   // negative branch offset
    sendWord("R7", 32'h1000_0004, 8'd10);  // positive offset falls to entry 4
    sendWord("R10", 32'h0000_0020, 8'd0);  // miss
    writeEntry(0, 0, 32'hAC00_0000, 32'hFC00_0000, 0, 8'd5);
    sendWord("R11", 32'hAC24_0008, 8'd11); // invalidated entry 0 no longer wins
    // Random stream with writes overlapping offered words.
    reqTag = "R8";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      instValid = ($urandom % 4) != 0;
      instWord = {($urandom % 2) ? 6'h2B : 6'($urandom), 5'($urandom % 4 + 28), 5'($urandom), 16'($urandom)};
      wrEn = ($urandom % 16) == 0;
      wrIdx = 5'($urandom); wrValid = ($urandom % 4) != 0;
      wrValue = {6'h2B, 5'($urandom % 4 + 28), 21'($urandom)};
      wrMask = ($urandom % 2) ? 32'hFC00_0000 : {$urandom} & 32'hFFE0_8000;
      wrSignOnly = $urandom; wrSeqId = 8'($urandom);
    end
    @(negedge clk);
    instValid = 0; wrEn = 0;
    repeat (3) @(negedge clk);
    finish();
  end

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish();
  end
endmodule